// File: doc/BRIEF.md
# Parallel SCSI Target Read Sequencer

This block is the device-side controller for a read transaction on an 8-bit parallel SCSI bus. It watches the bus until it has been idle for a set number of cycles. It then follows the arbitration that comes next and records which contender won. When the winner selects this device, the block answers by asserting BSY. From then on the block owns the transaction. It collects the command bytes, streams read bytes taken from a local source, returns a status byte and finishes with a completion message. After that it lets go of every line.

Each transfer phase is encoded on the MSG, C/D and I/O lines, written here as `{MSG,C/D,I/O}`. Every byte, in either direction, moves under a four-edge REQ/ACK handshake. The host-side device is called the initiator. The command format is deliberately small. The low four bits of the first command byte give the number of command bytes that follow. When that number is non-zero, the last command byte is the count of data bytes to return.

Top module: `scsi_tgt_seq`

## Requirements
- R1: When `rst_n` is low, or at the first clock edge that samples `bus_rst_i` high, the block releases BSY, REQ, MSG, C/D, I/O and `db_oe_o`. It abandons any transaction in progress and needs a new bus-free period and selection before it acts again.
- R2: A selection is considered only after BSY and SEL have both been low for at least `BUS_FREE_CYC` consecutive cycles, followed by an arbitration (BSY high, SEL low). The block asserts `bsy_o` at the first clock edge that samples SEL high and BSY low with a matching pattern. A SEL with no preceding bus-free period and arbitration is ignored.
- R3: The arbitration winner is the highest-numbered data line set while BSY is high and SEL is low. A selection whose initiator bit is not that winner is ignored, and `bsy_o` stays low.
- R4: A selection pattern is ignored unless exactly two data lines are set and one of them is bit `my_id_i`.
- R5: Once SEL has dropped, the block enters the command phase with `{MSG,C/D,I/O}` = 010. Bits [3:0] of the first command byte give the number N of further command bytes. If N > 0, the last command byte is the data length. If N = 0, or if the length is 0, there is no data phase.
- R6: REQ rises only at an edge that sampled ACK low. REQ falls at the first edge that samples ACK high. The phase lines are set at least one cycle before REQ rises, and they do not change while REQ is high.
- R7: In the data phase (`{MSG,C/D,I/O}` = 001) the block takes each byte from the local source with a one-cycle `rd_pop_o` pulse. `rd_pop_o` is high exactly while the block waits for a byte and `rd_valid_i` is high. The byte appears on `db_o` with `db_oe_o` before REQ rises, and bytes go out in source order.
- R8: The status phase (`{MSG,C/D,I/O}` = 011) sends the byte 0x00.
- R9: The message phase (`{MSG,C/D,I/O}` = 111) sends the completion byte 0x00. At the edge that samples ACK low after that byte, every line is released and BSY drops.
- R10: While ACK stays high after a byte, REQ stays low. No further byte is offered until ACK has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_rst_i | input | 1 | Bus reset line (active high) |
| bsy_i | input | 1 | BSY driven by other devices |
| sel_i | input | 1 | SEL line |
| ack_i | input | 1 | ACK from initiator |
| db_i | input | 8 | Data lines as observed |
| my_id_i | input | 3 | Configured ID of this device |
| rd_data_i | input | 8 | Next read byte from local source |
| rd_valid_i | input | 1 | Local source has a byte |
| bsy_o | output | 1 | BSY driven by this device |
| req_o | output | 1 | REQ |
| cd_o | output | 1 | C/D phase line |
| io_o | output | 1 | I/O phase line |
| msg_o | output | 1 | MSG phase line |
| db_o | output | 8 | Byte driven onto the data lines |
| db_oe_o | output | 1 | Data line drive enable |
| rd_pop_o | output | 1 | Consume one byte from local source |

## Verification
On every cycle, the assertions check the handshake ordering against ACK, the stability of phase lines and outgoing data while REQ is high, the set of legal phase codes, and quiet lines whenever BSY is low. They also check the release after a bus reset and the BSY answer to an accepted selection. Other properties depend on whole scenarios, and only the bench's scenarios can show them. These are the order of the phases, whether the data phase is skipped for the given command byte values, the source bytes arriving in order, and the rejection of selections without a bus-free period, with a losing initiator or with a foreign ID pattern.

// File: rtl/scsi_tgt_pkg.sv
package scsi_tgt_pkg;

  localparam int BUS_W = 8;
  localparam int ID_W  = $clog2(BUS_W);
  localparam int REM_W = 4;

  // {MSG, C/D, I/O}
  typedef enum logic [2:0] {
    PH_FREE  = 3'b000,
    PH_CMD   = 3'b010,
    PH_DIN   = 3'b001,
    PH_STAT  = 3'b011,
    PH_MSGIN = 3'b111
  } phase_e;

  localparam logic [BUS_W-1:0] STATUS_GOOD  = 8'h00;
  localparam logic [BUS_W-1:0] MSG_CMD_DONE = 8'h00;

  // {found, index of highest set bit}
  function automatic logic [ID_W:0] top_set_bit(input logic [BUS_W-1:0] v);
    logic [ID_W:0] r;
    r = '0;
    for (int i = 0; i < BUS_W; i++)
      if (v[i]) r = {1'b1, ID_W'(i)};
    return r;
  endfunction

  function automatic int count_ones(input logic [BUS_W-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < BUS_W; i++)
      if (v[i]) n++;
    return n;
  endfunction

  function automatic logic selection_match(input logic [BUS_W-1:0] v,
                                           input logic [ID_W-1:0]  own,
                                           input logic [ID_W-1:0]  win);
    logic [BUS_W-1:0] other;
    logic [ID_W:0]    t;
    other = v & ~(BUS_W'(1) << own);
    t     = top_set_bit(other);
    return v[own] && (count_ones(v) == 2) && t[ID_W] && (t[ID_W-1:0] == win);
  endfunction

  function automatic logic [REM_W-1:0] cmd_rem(input logic [BUS_W-1:0] b);
    return b[REM_W-1:0];
  endfunction

endpackage

// File: rtl/scsi_sel_det.sv
module scsi_sel_det
  import scsi_tgt_pkg::*;
#(
  parameter int BUS_FREE_CYC = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst_i,
  input  logic             busy_i,
  input  logic             bsy_i,
  input  logic             sel_i,
  input  logic [BUS_W-1:0] db_i,
  input  logic [ID_W-1:0]  my_id_i,
  output logic             sel_hit_o
);

  localparam int CNT_W = $clog2(BUS_FREE_CYC + 1);

  typedef enum logic [1:0] {A_WAIT, A_FREE, A_ARB} arb_e;

  arb_e             st;
  logic [CNT_W-1:0] idle_cnt;
  logic [ID_W-1:0]  winner;
  logic [ID_W:0]    lead;
  logic             line_idle;

  assign lead      = top_set_bit(db_i);
  assign line_idle = !bsy_i && !sel_i;
  assign sel_hit_o = (st == A_ARB) && sel_i && !bsy_i && !busy_i &&
                     selection_match(db_i, my_id_i, winner);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= A_WAIT;
      idle_cnt <= '0;
      winner   <= '0;
    end else if (bus_rst_i || busy_i) begin
      st       <= A_WAIT;
      idle_cnt <= '0;
    end else begin
      case (st)
        A_WAIT: begin
          if (!line_idle)
            idle_cnt <= '0;
          else if (idle_cnt == CNT_W'(BUS_FREE_CYC - 1)) begin
            st       <= A_FREE;
            idle_cnt <= '0;
          end else
            idle_cnt <= idle_cnt + 1'b1;
        end
        A_FREE: begin
          if (sel_i)
            st <= A_WAIT;
          else if (bsy_i) begin
            st     <= A_ARB;
            winner <= lead[ID_W-1:0];
          end
        end
        A_ARB: begin
          if (sel_i && !bsy_i)
            st <= A_WAIT;
          else if (!sel_i) begin
            if (!bsy_i)
              st <= A_WAIT;
            else if (lead[ID_W])
              winner <= lead[ID_W-1:0];
          end
        end
        default: st <= A_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/scsi_req_ack.sv
module scsi_req_ack
  import scsi_tgt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             ack_i,
  input  logic [BUS_W-1:0] db_i,
  output logic             req_o,
  output logic             done_o,
  output logic [BUS_W-1:0] rx_o
);

  typedef enum logic [1:0] {H_IDLE, H_ARM, H_REQ, H_REL} hs_e;

  hs_e st;

  assign req_o  = (st == H_REQ);
  assign done_o = (st == H_REL) && !ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= H_IDLE;
      rx_o <= '0;
    end else if (abort_i) begin
      st <= H_IDLE;
    end else begin
      case (st)
        H_IDLE: if (start_i) st <= H_ARM;
        H_ARM:  if (!ack_i)  st <= H_REQ;
        H_REQ: if (ack_i) begin
          rx_o <= db_i;
          st   <= H_REL;
        end
        H_REL:  if (!ack_i)  st <= H_IDLE;
        default: st <= H_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scsi_tgt_seq.sv
module scsi_tgt_seq
  import scsi_tgt_pkg::*;
#(
  parameter int BUS_FREE_CYC = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst_i,
  input  logic             bsy_i,
  input  logic             sel_i,
  input  logic             ack_i,
  input  logic [BUS_W-1:0] db_i,
  input  logic [ID_W-1:0]  my_id_i,
  input  logic [BUS_W-1:0] rd_data_i,
  input  logic             rd_valid_i,
  output logic             bsy_o,
  output logic             req_o,
  output logic             cd_o,
  output logic             io_o,
  output logic             msg_o,
  output logic [BUS_W-1:0] db_o,
  output logic             db_oe_o,
  output logic             rd_pop_o
);

  typedef enum logic [2:0] {
    T_IDLE, T_SEL, T_CMD, T_DWAIT, T_DATA, T_STAT, T_MSG
  } tst_e;

  tst_e             st;
  phase_e           ph;
  logic             hs_start;
  logic             hs_done;
  logic             sel_hit;
  logic [BUS_W-1:0] hs_rx;
  logic [BUS_W-1:0] db_q;
  logic [BUS_W-1:0] left;
  logic [REM_W-1:0] idx;
  logic [REM_W-1:0] rem;
  logic             cmd_last;
  logic [BUS_W-1:0] cmd_len;

  scsi_sel_det #(.BUS_FREE_CYC(BUS_FREE_CYC)) sel_det_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rst_i (bus_rst_i),
    .busy_i    (bsy_o),
    .bsy_i     (bsy_i),
    .sel_i     (sel_i),
    .db_i      (db_i),
    .my_id_i   (my_id_i),
    .sel_hit_o (sel_hit)
  );

  scsi_req_ack hs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort_i (bus_rst_i),
    .start_i (hs_start),
    .ack_i   (ack_i),
    .db_i    (db_i),
    .req_o   (req_o),
    .done_o  (hs_done),
    .rx_o    (hs_rx)
  );

  assign cmd_last = (idx == '0) ? (cmd_rem(hs_rx) == '0) : (idx == rem);
  assign cmd_len  = (idx == '0) ? '0 : hs_rx;

  always_comb begin
    case (st)
      T_CMD:          ph = PH_CMD;
      T_DWAIT, T_DATA: ph = PH_DIN;
      T_STAT:         ph = PH_STAT;
      T_MSG:          ph = PH_MSGIN;
      default:        ph = PH_FREE;
    endcase
  end

  assign {msg_o, cd_o, io_o} = ph;
  assign bsy_o    = (st != T_IDLE);
  assign db_o     = db_q;
  assign db_oe_o  = (st == T_DATA) || (st == T_STAT) || (st == T_MSG);
  assign rd_pop_o = (st == T_DWAIT) && rd_valid_i && !bus_rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= T_IDLE;
      hs_start <= 1'b0;
      db_q     <= '0;
      left     <= '0;
      idx      <= '0;
      rem      <= '0;
    end else if (bus_rst_i) begin
      st       <= T_IDLE;
      hs_start <= 1'b0;
    end else begin
      hs_start <= 1'b0;
      case (st)
        T_IDLE: if (sel_hit) st <= T_SEL;
        T_SEL: if (!sel_i) begin
          st       <= T_CMD;
          idx      <= '0;
          hs_start <= 1'b1;
        end
        T_CMD: if (hs_done) begin
          if (idx == '0) rem <= cmd_rem(hs_rx);
          if (cmd_last) begin
            if (cmd_len != '0) begin
              st   <= T_DWAIT;
              left <= cmd_len;
            end else begin
              st       <= T_STAT;
              db_q     <= STATUS_GOOD;
              hs_start <= 1'b1;
            end
          end else begin
            idx      <= idx + 1'b1;
            hs_start <= 1'b1;
          end
        end
        T_DWAIT: if (rd_valid_i) begin
          db_q     <= rd_data_i;
          hs_start <= 1'b1;
          st       <= T_DATA;
        end
        T_DATA: if (hs_done) begin
          if (left == BUS_W'(1)) begin
            st       <= T_STAT;
            db_q     <= STATUS_GOOD;
            hs_start <= 1'b1;
          end else begin
            left <= left - 1'b1;
            st   <= T_DWAIT;
          end
        end
        T_STAT: if (hs_done) begin
          st       <= T_MSG;
          db_q     <= MSG_CMD_DONE;
          hs_start <= 1'b1;
        end
        T_MSG: if (hs_done) st <= T_IDLE;
        default: st <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scsi_tgt_seq_chk.sv
module scsi_tgt_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rst_i,
  input logic       ack_i,
  input logic       bsy_o,
  input logic       req_o,
  input logic       cd_o,
  input logic       io_o,
  input logic       msg_o,
  input logic [7:0] db_o,
  input logic       db_oe_o,
  input logic       rd_pop_o,
  input logic       sel_hit
);

  logic [2:0] ph;
  assign ph = {msg_o, cd_o, io_o};

  // R1
  bus_rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> (!bsy_o && !req_o && !db_oe_o && ph == 3'b000));

  // R2
  sel_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hit && !bus_rst_i) |=> bsy_o);

  // R5
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 3'b000 || ph == 3'b010 || ph == 3'b001 || ph == 3'b011 || ph == 3'b111));

  // R6 R10
  req_rise_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> !$past(ack_i));

  // R6
  req_fall_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> ($past(ack_i) || $past(bus_rst_i)));

  // R6
  phase_stable_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> $stable(ph));

  // R7
  db_stable_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && db_oe_o) |-> $stable(db_o));

  // R7
  pop_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop_o |-> (ph == 3'b001 && !req_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bsy_o |-> (!req_o && ph == 3'b000 && !db_oe_o));

endmodule

bind scsi_tgt_seq scsi_tgt_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rst_i (bus_rst_i),
  .ack_i     (ack_i),
  .bsy_o     (bsy_o),
  .req_o     (req_o),
  .cd_o      (cd_o),
  .io_o      (io_o),
  .msg_o     (msg_o),
  .db_o      (db_o),
  .db_oe_o   (db_oe_o),
  .rd_pop_o  (rd_pop_o),
  .sel_hit   (sel_hit)
);

// File: tb/scsi_tgt_seq_tb_top.sv
module scsi_tgt_seq_tb_top;

  localparam logic [2:0] P_FREE = 3'b000;
  localparam logic [2:0] P_CMD  = 3'b010;
  localparam logic [2:0] P_DIN  = 3'b001;
  localparam logic [2:0] P_STAT = 3'b011;
  localparam logic [2:0] P_MSG  = 3'b111;

  logic       clk = 1'b0;
  logic       rst_n, bus_rst_i, bsy_i, sel_i, ack_i, rd_valid_i;
  logic [7:0] db_i, rd_data_i;
  logic [2:0] my_id_i;
  logic       bsy_o, req_o, cd_o, io_o, msg_o, db_oe_o, rd_pop_o;
  logic [7:0] db_o;

  int checks = 0;
  int fails  = 0;
  int src_idx = 0;
  int exp_src = 0;
  bit pop_seen = 1'b0;

  always #10 clk = ~clk;

  scsi_tgt_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i), .bsy_i(bsy_i),
    .sel_i(sel_i), .ack_i(ack_i), .db_i(db_i), .my_id_i(my_id_i),
    .rd_data_i(rd_data_i), .rd_valid_i(rd_valid_i), .bsy_o(bsy_o),
    .req_o(req_o), .cd_o(cd_o), .io_o(io_o), .msg_o(msg_o), .db_o(db_o),
    .db_oe_o(db_oe_o), .rd_pop_o(rd_pop_o)
  );

  function automatic logic [7:0] src_byte(input int i);
    return 8'((i * 29 + 19) ^ (i >> 2));
  endfunction

  function automatic logic [2:0] ph_now();
    return {msg_o, cd_o, io_o};
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic bus_idle(input int n);
    bsy_i = 0; sel_i = 0; ack_i = 0; db_i = '0;
    repeat (n) step();
  endtask

  // local byte source
  initial begin
    rd_valid_i = 0;
    rd_data_i  = '0;
    forever begin
      @(negedge clk);
      if (pop_seen) src_idx++;
      rd_valid_i = ($urandom_range(3) != 0);
      rd_data_i  = src_byte(src_idx);
      #1 pop_seen = rd_pop_o;
    end
  end

  // initiator side of one byte
  task automatic xfer(input logic [2:0] exp_ph, input bit drive, input logic [7:0] out_b,
                      input logic [7:0] exp_in, input int hold, input string rq);
    int n;
    n = 0;
    while (!req_o && n < 300) begin step(); n++; end
    chk(req_o, {rq, " REQ raised"}, req_o, 1);
    chk(ph_now() == exp_ph, {rq, " phase code"}, ph_now(), exp_ph);
    if (!drive) chk(db_oe_o && db_o == exp_in, {rq, " byte"}, db_o, exp_in);
    if (drive) db_i = out_b;
    ack_i = 1;
    step();
    chk(!req_o, "R6 REQ drops on ACK", req_o, 0);
    for (int h = 0; h < hold; h++) begin
      step();
      chk(!req_o, "R10 REQ low while ACK held", req_o, 0);
    end
    ack_i = 0;
    db_i  = '0;
    step();
  endtask

  task automatic select_ok(input logic [2:0] tid, input logic [2:0] iid, input logic [7:0] extra);
    my_id_i = tid;
    bus_idle(6);
    bsy_i = 1; db_i = (8'(1) << iid) | extra;
    step(); step();
    sel_i = 1; db_i = (8'(1) << iid) | (8'(1) << tid);
    step();
    bsy_i = 0;
    step();
    chk(bsy_o == 1'b1, "R2 BSY answer", bsy_o, 1);
    chk(!req_o && ph_now() == P_FREE, "R2 no phase yet", ph_now(), 0);
    sel_i = 0; db_i = '0;
  endtask

  task automatic txn(input logic [2:0] tid, input logic [2:0] iid, input logic [7:0] extra,
                     input int rem, input int len, input int hold);
    int elen;
    logic [7:0] b;
    select_ok(tid, iid, extra);
    b = {4'($urandom_range(15)), 4'(rem)};
    xfer(P_CMD, 1, b, 0, hold, "R5 cmd0");
    for (int k = 1; k <= rem; k++) begin
      b = (k == rem) ? 8'(len) : 8'($urandom_range(255));
      xfer(P_CMD, 1, b, 0, hold, "R5 cmd");
    end
    elen = (rem > 0) ? len : 0;
    for (int k = 0; k < elen; k++) begin
      xfer(P_DIN, 0, 0, src_byte(exp_src), hold, "R7 data");
      exp_src++;
    end
    xfer(P_STAT, 0, 0, 8'h00, hold, "R8 status");
    xfer(P_MSG, 0, 0, 8'h00, hold, "R9 message");
    chk(!bsy_o && !db_oe_o && ph_now() == P_FREE && !req_o, "R9 release", bsy_o, 0);
  endtask

  task automatic reject(input logic [2:0] tid, input int idle, input bit do_arb,
                        input logic [7:0] arb, input logic [7:0] selm, input string rq);
    my_id_i = tid;
    bus_idle(idle);
    if (do_arb) begin
      bsy_i = 1; db_i = arb;
      step(); step();
      sel_i = 1; db_i = selm;
      step();
    end
    bsy_i = 0; sel_i = 1; db_i = selm;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(!bsy_o, rq, bsy_o, 0);
    end
    sel_i = 0; db_i = '0;
    step();
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; bus_rst_i = 0; my_id_i = 3'd2;
    bus_idle(3);
    chk(!bsy_o && !req_o && !db_oe_o && ph_now() == P_FREE, "R1 reset state", bsy_o, 0);
    rst_n = 1;

    // directed
    txn(3'd2, 3'd7, 8'h05, 0, 0, 0);          // R5 no further cmd bytes -> no data
    txn(3'd0, 3'd7, 8'h00, 1, 0, 0);          // R5 zero length
    txn(3'd7, 3'd6, 8'h21, 2, 1, 1);          // R7 single byte, R10 hold
    txn(3'd4, 3'd1, 8'h00, 3, 5, 2);

    // R2 no bus-free period before arbitration
    reject(3'd2, 2, 1, 8'h08, 8'h0C, "R2 no bus-free");
    // R2 SEL without arbitration
    reject(3'd2, 6, 0, 8'h00, 8'h0C, "R2 SEL without arbitration");
    // R3 initiator lost arbitration to line 6
    reject(3'd2, 6, 1, 8'h48, 8'h0C, "R3 non-winner selects");
    // R4 own ID absent
    reject(3'd2, 6, 1, 8'h08, 8'h28, "R4 foreign ID");
    // R4 three lines set
    reject(3'd2, 6, 1, 8'h08, 8'h2C, "R4 three bits");

    // R1 bus reset during command phase
    select_ok(3'd5, 3'd6, 8'h00);
    xfer(P_CMD, 1, 8'h83, 0, 0, "R5 cmd0");
    bus_rst_i = 1;
    step();
    chk(!bsy_o && !req_o && ph_now() == P_FREE && !db_oe_o, "R1 bus reset release", bsy_o, 0);
    bus_rst_i = 0;
    // R1 bus reset while REQ high
    select_ok(3'd5, 3'd6, 8'h00);
    while (!req_o) step();
    bus_rst_i = 1;
    step();
    chk(!bsy_o && !req_o, "R1 reset with REQ high", req_o, 0);
    bus_rst_i = 0;
    step();
    chk(!bsy_o, "R1 stays idle", bsy_o, 0);

    // random
    for (int t = 0; t < 30; t++) begin
      logic [2:0] tid, iid;
      logic [7:0] extra;
      tid = 3'($urandom_range(7));
      iid = 3'(tid + 3'($urandom_range(6)) + 3'd1);
      extra = 8'($urandom_range(255)) & ((8'(1) << iid) - 8'd1) & ~(8'(1) << tid);
      txn(tid, iid, extra, $urandom_range(4), $urandom_range(6), $urandom_range(2));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule